// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the 32-bit program counter of a word-aligned instruction stream and chooses the next counter value on every clock. A two-bit select input chooses the source. It can be the sequential address, a conditional relative branch that depends on the ALU zero flag, or an absolute jump built from a 26-bit target field. The current counter value is driven out as the fetch address. A small built-in instruction store, whose contents are given as a parameter array, returns the 32-bit word at that address in the same cycle.

One incrementer produces the sequential address. The branch adder takes that sum as its base, and the jump value takes its top nibble from the same sum. The counter has no load enable: it takes the selected value on every rising edge unless reset is high.

Top module: `pcseq_top`

## Requirements
- R1: A high `rst` at a rising edge sets `pc_o` to 0x00000000 after that edge, whatever the other inputs are.
- R2: With `sel_i` = 2'b00 (sequential), `pc_o` after the edge equals its previous value plus 4.
- R3: With `sel_i` = 2'b01 (branch) and `zero_i` = 1, `pc_o` after the edge equals (old PC + 4) + sign-extended `imm_i` multiplied by 4. Negative offsets move backwards.
- R4: With `sel_i` = 2'b01 and `zero_i` = 0, `pc_o` after the edge equals old PC + 4. `imm_i` has no effect.
- R5: With `sel_i[1]` = 1 (jump), `pc_o` after the edge equals {(old PC + 4)[31:28], `tgt_i`, 2'b00}.
- R6: Jump takes priority over branch. With `sel_i` = 2'b11, the jump value of R5 is loaded whatever `zero_i` and `imm_i` are.
- R7: `pc_o[1:0]` is always 2'b00.
- R8: `instr_o` equals word `pc_o[31:2]` of the `ROM_IMAGE` parameter when that index is below `ROM_WORDS`. Otherwise it equals 32'h0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 2 | Next-PC select: bit 1 jump, bit 0 branch, 00 sequential |
| zero_i | input | 1 | ALU zero flag, the branch condition |
| imm_i | input | 16 | Signed word offset for branches |
| tgt_i | input | 26 | Word target field for jumps |
| pc_o | output | 32 | Current program counter, the fetch address |
| instr_o | output | 32 | Instruction word at `pc_o` |

## Verification
The embedded assertions check the counter's step on every cycle. They cover the reset value, the +4 step for sequential and not-taken branches, the taken-branch target, the jump value with its priority over branch, and the two zero alignment bits. The bench's scenarios are what show the counter moving through a real instruction sequence. These include a backward taken branch, a jump whose target lies beyond the instruction store so that the fetched word reads zero, and a reset applied mid-run. The bench also compares the fetched word against the image on every cycle, which no single-cycle property covers.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int XLEN     = 32;
    localparam int OFFS_W   = 16;
    localparam int TGT_W    = 26;
    localparam int STEP     = 4;

    typedef logic [XLEN-1:0] addr_t;

    // bit 1: jump, bit 0: branch; jump wins when both set
    typedef enum logic [1:0] {
        NPC_SEQ    = 2'b00,
        NPC_BRANCH = 2'b01,
        NPC_JUMP   = 2'b10,
        NPC_BOTH   = 2'b11
    } npc_sel_e;

    typedef struct packed {
        npc_sel_e           sel;
        logic               zero;
        logic [OFFS_W-1:0]  offs;
        logic [TGT_W-1:0]   tgt;
    } npc_req_t;

    function automatic addr_t offs_to_bytes(input logic [OFFS_W-1:0] o);
        return {{(XLEN-OFFS_W-2){o[OFFS_W-1]}}, o, 2'b00};
    endfunction

    function automatic addr_t jump_addr(input addr_t seq, input logic [TGT_W-1:0] t);
        return {seq[XLEN-1:TGT_W+2], t, 2'b00};
    endfunction

endpackage

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
(
    input  addr_t    pc,
    input  npc_req_t req,
    output addr_t    npc
);
    addr_t seq_a;
    addr_t br_a;
    addr_t jmp_a;
    addr_t after_br;

    always_comb begin
        seq_a = pc + addr_t'(STEP);
        br_a  = seq_a + offs_to_bytes(req.offs);
        jmp_a = jump_addr(seq_a, req.tgt);
        after_br = (req.sel[0] && req.zero) ? br_a : seq_a;
        npc      = req.sel[1] ? jmp_a : after_br;
    end
endmodule

// File: rtl/pcseq_reg.sv
module pcseq_reg
    import pcseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t d,
    output addr_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R7
    pc_align_chk: assert property (@(posedge clk) disable iff (rst) q[1:0] == 2'b00);
endmodule

// File: rtl/pcseq_rom.sv
module pcseq_rom #(
    parameter int ROM_WORDS = 16,
    parameter logic [31:0] ROM_IMAGE [ROM_WORDS] = '{default: 32'h0}
) (
    input  logic [29:0] word_idx,
    output logic [31:0] data
);
    localparam int IDX_W = (ROM_WORDS > 1) ? $clog2(ROM_WORDS) : 1;

    logic in_range;

    always_comb begin
        in_range = word_idx < 30'(ROM_WORDS);
        data     = in_range ? ROM_IMAGE[word_idx[IDX_W-1:0]] : 32'h0;
    end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int ROM_WORDS = 16,
    parameter logic [31:0] ROM_IMAGE [ROM_WORDS] = '{default: 32'h0}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  sel_i,
    input  logic        zero_i,
    input  logic [15:0] imm_i,
    input  logic [25:0] tgt_i,
    output logic [31:0] pc_o,
    output logic [31:0] instr_o
);
    npc_req_t req;
    addr_t    pc_q;
    addr_t    pc_d;

    always_comb begin
        req.sel  = npc_sel_e'(sel_i);
        req.zero = zero_i;
        req.offs = imm_i;
        req.tgt  = tgt_i;
    end

    pcseq_next u_next (.pc(pc_q), .req(req), .npc(pc_d));
    pcseq_reg  u_reg  (.clk(clk), .rst(rst), .d(pc_d), .q(pc_q));
    pcseq_rom #(.ROM_WORDS(ROM_WORDS), .ROM_IMAGE(ROM_IMAGE))
        u_rom (.word_idx(pc_q[31:2]), .data(instr_o));

    assign pc_o = pc_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> pc_o == 32'h0);
    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        sel_i == 2'b00 |=> pc_o == $past(pc_o) + 32'd4);
    // R4
    br_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 2'b01 && !zero_i) |=> pc_o == $past(pc_o) + 32'd4);
    // R3
    br_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 2'b01 && zero_i) |=>
        pc_o == $past(pc_o) + 32'd4 + ($past({{14{imm_i[15]}}, imm_i, 2'b00})));
    // R5
    jump_chk: assert property (@(posedge clk) disable iff (rst)
        sel_i[1] |=> pc_o[27:0] == {$past(tgt_i), 2'b00});
    // R6
    jump_prio_chk: assert property (@(posedge clk) disable iff (rst)
        sel_i == 2'b11 |=> pc_o[27:0] == {$past(tgt_i), 2'b00});
endmodule

// File: tb/pcseq_top_tb_top.sv
module pcseq_top_tb_top;
    localparam int WORDS = 16;
    localparam logic [31:0] IMG [WORDS] = '{
        32'h20010001, 32'h20020002, 32'h00221820, 32'h10220003,
        32'h8c040000, 32'hac040004, 32'h08000002, 32'h34a50f0f,
        32'h00a62022, 32'h11110000, 32'h22220000, 32'h33330000,
        32'h44440000, 32'h55550000, 32'h66660000, 32'hdeadbeef};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sel = 2'b00;
    logic        zero = 1'b0;
    logic [15:0] imm = '0;
    logic [25:0] tgt = '0;
    logic [31:0] pc_o, instr_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_pc;
    bit done = 0;

    pcseq_top #(.ROM_WORDS(WORDS), .ROM_IMAGE(IMG)) dut_i (
        .clk(clk), .rst(rst), .sel_i(sel), .zero_i(zero),
        .imm_i(imm), .tgt_i(tgt), .pc_o(pc_o), .instr_o(instr_o));

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] rom_at(input logic [31:0] a);
        int idx = int'(a >> 2);
        if (a[31:2] < WORDS) return IMG[idx];
        return 32'h0;
    endfunction

    task automatic check_all(input string tag);
        chk(tag, pc_o, model_pc);
        chk("R7", {30'h0, pc_o[1:0]}, 32'h0);
        chk("R8", instr_o, rom_at(model_pc));
    endtask

    // drive at negedge, model next value, compare at following negedge
    task automatic step(input logic [1:0] s, input logic z, input logic [15:0] o,
                        input logic [25:0] t, input string tag);
        logic [31:0] nxt;
        sel = s; zero = z; imm = o; tgt = t;
        nxt = model_pc + 32'd4;
        if (s[1])
            nxt = {nxt[31:28], t, 2'b00};
        else if (s[0] && z)
            nxt = nxt + 32'($signed(o) * 4);
        @(negedge clk);
        model_pc = nxt;
        check_all(tag);
    endtask

    initial begin
        model_pc = 32'h0;
        @(negedge clk);
        @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        step(2'b00, 1'b0, 16'h0, 26'h0, "R2");
        step(2'b00, 1'b1, 16'hffff, 26'h3, "R2");
        step(2'b00, 1'b0, 16'h0, 26'h0, "R2");        // pc = 12
        step(2'b01, 1'b1, 16'hfffe, 26'h0, "R3");     // back to 8
        step(2'b01, 1'b0, 16'hfffe, 26'h0, "R4");     // 12
        step(2'b10, 1'b0, 16'h0, 26'h5, "R5");        // 20
        step(2'b11, 1'b1, 16'h0001, 26'h2, "R6");     // 8
        step(2'b01, 1'b1, 16'h0003, 26'h0, "R3");     // 24
        step(2'b10, 1'b1, 16'h0, 26'h28, "R5");       // 160, outside store
        chk("R8", instr_o, 32'h0);
        step(2'b00, 1'b0, 16'h0, 26'h0, "R2");        // 164
        step(2'b10, 1'b0, 16'h0, 26'hf, "R5");        // 60, last word
        chk("R8", instr_o, 32'hdeadbeef);
        rst = 1'b1;
        sel = 2'b10; tgt = 26'h9;
        @(negedge clk);
        model_pc = 32'h0;
        check_all("R1");
        rst = 1'b0;
        step(2'b00, 1'b0, 16'h0, 26'h0, "R2");
        done = 1;
    end

    initial begin
        int n = 0;
        while (!done && n < 5000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        #1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule